// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that shifts 8-bit or 16-bit words out on `sdo` and in from `sdi`, and generates `sck` from the system clock. Both data paths pass through a single shift register. A transmit holding buffer sits in front of it and a receive holding buffer sits behind it. Software can therefore queue the next word while the current one is still shifting, and can collect a finished word at its own pace.

Three configuration inputs set the serial clock. One sets the idle level of `sck`. One sets which `sck` transition launches data. One sets whether `sdi` is captured in the middle or at the end of each bit. A further input selects the word length. An even clock divider sets the `sck` rate. Each bit is two half periods of `cfg_half_div+1` system clocks each. The half with index 0 is the first half of the bit.

A write strobe loads a word. If the shifter is idle, the word starts at once. If the shifter is busy, the word is held in the buffer and `tx_full` is set. A read strobe acknowledges the receive buffer. A one-cycle `irq` pulse marks each finished word.

Top module: `spi_dbuf_master`

## Requirements
- R1: While reset is held, and after it is released, `sck` equals `cfg_idle_hi`, and `tx_full`, `rx_full` and `irq` are 0.
- R2: When no word is shifting, `sck` stays at the idle level. During a word, `sck` makes exactly N active pulses, where N is 16 when `cfg_wide`=1 and 8 when `cfg_wide`=0.
- R3: Data leaves `sdo` most significant bit first. With `cfg_edge`=1, `sdo` changes on active-to-idle transitions and is stable at each idle-to-active transition. With `cfg_edge`=0, `sdo` changes on idle-to-active transitions and is stable at each active-to-idle transition.
- R4: With `cfg_smp_end`=0, each received bit is the `sdi` value in the last system cycle of the first half of the bit. With `cfg_smp_end`=1, it is the value in the last system cycle of the second half.
- R5: A write while idle starts the word at once. `rx_full` rises exactly 2·N·(`cfg_half_div`+1) clock edges after the edge that samples `wr_en`.
- R6: A write during a transfer is held and sets `tx_full`. `tx_full` clears when the held word enters the shifter. The held word begins at the edge where the previous word ends, so two queued words take exactly twice the single-word time.
- R7: At the end of a word, the received word is placed on `rd_data` and `rx_full` is set. In 8-bit mode, bits 15:8 of `rd_data` are 0. A `rd_en` strobe clears `rx_full` on the next edge.
- R8: `irq` is high for exactly one cycle, one cycle after `rx_full` rises.
- R9: The `sck` period is 2·(`cfg_half_div`+1) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_idle_hi | input | 1 | Idle level of sck |
| cfg_edge | input | 1 | 1: data changes on the active-to-idle transition; 0: on the idle-to-active transition |
| cfg_smp_end | input | 1 | 0: sample sdi mid-bit; 1: sample at the end of the bit |
| cfg_wide | input | 1 | 1: 16-bit words; 0: 8-bit words |
| cfg_half_div | input | DIV_W | Half sck period minus one, in system clocks |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 16 | Transmit word; only bits 7:0 are used in 8-bit mode |
| rd_en | input | 1 | Read strobe; clears rx_full |
| rd_data | output | 16 | Receive holding buffer |
| tx_full | output | 1 | A queued word is waiting |
| rx_full | output | 1 | The receive buffer holds an unread word |
| irq | output | 1 | One-cycle end-of-word pulse |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The latencies are fixed. `rx_full` is due exactly 2·N·(D+1) edges after the write edge, and `irq` one edge after that. A queued word finishes 2·N·(D+1) edges after the first one. The bench counts falling clock edges from the write, samples every output at falling edges, and requires each event on the exact count, not merely within a window. `sdi` is looped back from `sdo`, inverted while `sck` is active. This makes the mid-bit and end-of-bit sample points give complementary words, so the expected receive word follows arithmetically from the mode bits.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_idle_hi,
  input  logic             cfg_edge,
  input  logic             cfg_smp_end,
  input  logic             cfg_wide,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             rd_en,
  output logic [15:0]      rd_data,
  output logic             tx_full,
  output logic             rx_full,
  output logic             irq,
  output logic             sck,
  output logic             sdo,
  input  logic             sdi
);

  logic             busy;
  logic [15:0]      sr, tx_buf;
  logic [4:0]       hidx;
  logic [DIV_W-1:0] half_cnt;
  logic             mid_bit, end_d;
  logic             tick, word_end, start_now;
  logic [15:0]      shifted;

  assign tick      = busy && (half_cnt == cfg_half_div);
  assign word_end  = tick && (hidx == (cfg_wide ? 5'd31 : 5'd15));
  assign start_now = wr_en && (!busy || (word_end && !tx_full));
  assign shifted   = {sr[14:0], cfg_smp_end ? sdi : mid_bit};

  assign sck = cfg_idle_hi ^ (busy && (hidx[0] ^ ~cfg_edge));
  assign sdo = cfg_wide ? sr[15] : sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sr       <= '0;
      hidx     <= '0;
      half_cnt <= '0;
      mid_bit  <= 1'b0;
    end else if (start_now) begin
      sr       <= wr_data;
      busy     <= 1'b1;
      hidx     <= '0;
      half_cnt <= '0;
    end else if (word_end) begin
      sr       <= tx_full ? tx_buf : shifted;
      busy     <= tx_full;
      hidx     <= '0;
      half_cnt <= '0;
    end else if (tick) begin
      half_cnt <= '0;
      hidx     <= hidx + 5'd1;
      if (hidx[0]) sr <= shifted;
      else         mid_bit <= sdi;
    end else if (busy) begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
    end else if (wr_en && !start_now) begin
      tx_buf  <= wr_data;
      tx_full <= 1'b1;
    end else if (word_end && tx_full) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rx_full <= 1'b0;
      end_d   <= 1'b0;
      irq     <= 1'b0;
    end else begin
      end_d <= word_end;
      irq   <= end_d;
      if (word_end) begin
        rd_data <= cfg_wide ? shifted : {8'h00, shifted[7:0]};
        rx_full <= 1'b1;
      end else if (rd_en) begin
        rx_full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spi_dbuf_master_props.sv
module spi_dbuf_master_props (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic [4:0] hidx,
  input logic       cfg_idle_hi,
  input logic       sck,
  input logic       sdo,
  input logic       tx_full,
  input logic       rx_full,
  input logic       irq
);

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck == cfg_idle_hi);

  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(hidx)) |-> $stable(sdo));

  p_queue_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> busy);

  p_rx_from_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(busy));

  p_irq_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |=> irq);

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

endmodule

bind spi_dbuf_master spi_dbuf_master_props u_props (
  .clk(clk), .rst_n(rst_n), .busy(busy), .hidx(hidx),
  .cfg_idle_hi(cfg_idle_hi), .sck(sck), .sdo(sdo),
  .tx_full(tx_full), .rx_full(rx_full), .irq(irq)
);

// File: tb/spi_dbuf_master_test.sv
`timescale 1ns/1ps
module spi_dbuf_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_idle_hi = 1'b1, cfg_edge = 1'b0, cfg_smp_end = 1'b0, cfg_wide = 1'b0;
  logic [7:0] cfg_half_div = 8'd0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic tx_full, rx_full, irq, sck, sdo, sdi;

  int checks = 0, errors = 0;
  logic [31:0] cap;
  int ncap, nact;
  logic prev_sck;

  always #2.5 clk = ~clk;

  assign sdi = sdo ^ (sck != cfg_idle_hi);

  spi_dbuf_master #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_idle_hi(cfg_idle_hi), .cfg_edge(cfg_edge),
    .cfg_smp_end(cfg_smp_end), .cfg_wide(cfg_wide), .cfg_half_div(cfg_half_div),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .tx_full(tx_full), .rx_full(rx_full), .irq(irq), .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  always @(negedge clk) begin
    if (sck !== prev_sck) begin
      if ((sck != cfg_idle_hi) == cfg_edge) begin
        cap  = {cap[30:0], sdo};
        ncap = ncap + 1;
      end
      if (sck != cfg_idle_hi) nact = nact + 1;
    end
    prev_sck = sck;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_rx(input logic [15:0] w);
    logic [15:0] m = cfg_wide ? 16'hFFFF : 16'h00FF;
    return (w ^ ((cfg_smp_end == cfg_edge) ? 16'hFFFF : 16'h0000)) & m;
  endfunction

  task automatic clear_mon();
    @(negedge clk);
    @(negedge clk);
    ncap = 0; nact = 0; cap = '0;
  endtask

  task automatic one_word(input logic [15:0] w);
    int n = cfg_wide ? 16 : 8;
    int t = 2 * n * (int'(cfg_half_div) + 1);
    int j = 0;
    logic [15:0] m = cfg_wide ? 16'hFFFF : 16'h00FF;
    clear_mon();
    wr_data = w; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check(tx_full == 1'b0, "R5 idle write not queued", tx_full, 0);
    while (!rx_full && j < t + 4) begin @(negedge clk); j++; end
    check(j == t, "R5 word latency", j, t);
    check(rd_data == expect_rx(w), "R4 R7 received word", rd_data, expect_rx(w));
    check(sck == cfg_idle_hi, "R2 sck idle after word", sck, cfg_idle_hi);
    check(nact == n, "R2 active pulses", nact, n);
    check(ncap == n && (cap[15:0] & m) == (w & m), "R3 sdo MSB first", cap[15:0] & m, w & m);
    check(irq == 1'b0, "R8 irq not yet", irq, 0);
    @(negedge clk);
    check(irq == 1'b1, "R8 irq one cycle later", irq, 1);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rx_full == 1'b0 && irq == 1'b0, "R7 R8 read clears, pulse ends", {rx_full, irq}, 0);
  endtask

  task automatic period_check();
    int d = int'(cfg_half_div) + 1;
    int cnt = 0;
    int p1 = -1, p2 = -1;
    clear_mon();
    wr_data = 16'h5A5A; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    for (int k = 0; k < 40 * d && p2 < 0; k++) begin
      @(negedge clk);
      if (nact != cnt) begin
        if (p1 < 0) p1 = k; else p2 = k;
        cnt = nact;
      end
    end
    check(p2 - p1 == 2 * d, "R9 sck period", p2 - p1, 2 * d);
    while (!rx_full) @(negedge clk);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sck == 1'b1 && !tx_full && !rx_full && !irq, "R1 during reset", {sck, tx_full, rx_full, irq}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck == 1'b1 && !tx_full && !rx_full && !irq, "R1 after reset", {sck, tx_full, rx_full, irq}, 4'b1000);

    for (int c = 0; c < 16; c++) begin
      cfg_idle_hi  = c[0];
      cfg_edge     = c[1];
      cfg_smp_end  = c[2];
      cfg_wide     = c[3];
      cfg_half_div = 8'(c % 3);
      one_word(16'hA5C3 ^ 16'(c * 16'h1357));
      one_word(16'h0F81 ^ 16'(c * 16'h2468));
    end

    for (int d = 0; d < 4; d++) begin
      cfg_half_div = 8'(d);
      period_check();
    end

    cfg_idle_hi = 1'b1; cfg_edge = 1'b0; cfg_smp_end = 1'b0; cfg_wide = 1'b0; cfg_half_div = 8'd1;
    begin
      int t = 2 * 8 * 2;
      int j = 0, got = 0;
      int at1 = -1, at2 = -1;
      clear_mon();
      wr_data = 16'h00C6; wr_en = 1'b1;
      @(negedge clk); wr_data = 16'h0039;
      @(negedge clk); wr_en = 1'b0;
      check(tx_full == 1'b1, "R6 queued word sets tx_full", tx_full, 1);
      j = 1;
      while (j < 2 * t + 4 && got < 2) begin
        rd_en = 1'b0;
        if (rx_full) begin
          got++;
          if (got == 1) begin
            at1 = j;
            check(tx_full == 1'b0, "R6 tx_full clears on load", tx_full, 0);
            check(rd_data == expect_rx(16'h00C6), "R6 first word", rd_data, expect_rx(16'h00C6));
          end else begin
            at2 = j;
            check(rd_data == expect_rx(16'h0039), "R6 second word", rd_data, expect_rx(16'h0039));
          end
          rd_en = 1'b1;
        end
        @(negedge clk); j++;
      end
      rd_en = 1'b0;
      check(at1 == t, "R6 first word time", at1, t);
      check(at2 == 2 * t, "R6 no gap before queued word", at2, 2 * t);
      check(ncap == 16 && cap[15:0] == 16'hC639, "R3 R6 back-to-back sdo", cap[15:0], 16'hC639);
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule